// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level table held in memory. A core hands it one request at a time. The request carries a virtual address and a flag that tells a write access from a read. The walker first reads one 4-byte entry from the directory. It finds the directory in memory from a stored frame number, which is page aligned. It then reads one 4-byte entry from the table that the directory entry points to. From that table entry it forms the physical address. A directory entry may instead describe a 4 MB region directly, but only when large regions are enabled. In that case the walk ends after the first read.

Every entry the walker uses gets its "used" status bit set. The last entry of a write access also gets its "modified" status bit set. The walker does this by writing the updated entry back to the same address, right after the read. It writes only when a bit actually changes. If an entry is marked absent, the walk stops at once. The walker then returns a fault to the permission-check logic that follows it.

The request side is valid/ready. A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high. Ready is high only while the walker is idle, so the core must hold its request until it is taken. The response is a single-cycle strobe with no back-pressure, because the consumer must always accept it. The memory port is also valid/ready, with at most one access outstanding.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready_o` is high only when the walker is idle, with no memory access pending and no response showing. After a request is taken, ready stays low until the response strobe has been given.
- R2: The first memory access of a walk is a read (`mem_we_o`=0). Its address is {directory frame, VA[31:22], 2'b00}.
- R3: A new directory frame number written through `base_we_i` while a walk is running does not affect that walk. The walk that follows uses the new value.
- R4: For a walk that takes the small-page path, the second read is at {directory entry[31:12], VA[21:12], 2'b00}.
- R5: On a small-page walk with no fault, `rsp_paddr_o` = {table entry[31:12], VA[11:0]}.
- R6: The large-page path applies when `pse_en_i`=1 and bit 7 of the directory entry is 1. The walk then makes no table read, and `rsp_paddr_o` = {directory entry[31:22], VA[21:0]}.
- R7: When `pse_en_i`=0, bit 7 of the directory entry has no effect, and the walk reads a table entry as in R4 and R5.
- R8: If bit 0 (present) of the directory entry or of the table entry is 0, the walk ends. `rsp_fault_o`=1 is given with the response, and no write-back occurs.
- R9: A used entry with bit 5 (accessed) clear is written back, with bit 5 set, at the address it was read from. The write comes directly after the read and before any further access.
- R10: On a write access, the final entry of the walk is written back with bit 6 (dirty) set. A read never sets bit 6. An entry whose bits would not change is not written.
- R11: `rsp_valid_o` is high for exactly one cycle for each request that is taken.
- R12: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady. Read data is taken in the cycle of the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we_i | input | 1 | Load a new directory frame number |
| base_frame_i | input | 20 | Directory frame number (address bits 31:12) |
| pse_en_i | input | 1 | Enable large (4 MB) regions |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Not-present fault, qualified by rsp_valid_o |
| rsp_paddr_o | output | 32 | Physical address, qualified by rsp_valid_o |
| mem_valid_o | output | 1 | Memory access request |
| mem_ready_i | input | 1 | Memory access completes this cycle |
| mem_we_o | output | 1 | Access is a write-back |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Updated entry for a write-back |
| mem_rdata_i | input | 32 | Entry read, valid with mem_ready_i |

## Verification
The bench tracks the status bits through the walks. It starts with both the used and modified bits clear, then repeats the same address, then makes a write access. Each walk has an exact read count and write count. A design that writes back on every walk, or sets the modified bit on reads, shows up in the write count and in the memory contents. It also covers an entry that has the large-region bit set, with large regions both enabled and disabled. A walker that ignores the enable would report one read and the wrong address. A walker that forgets to stop at the first level would issue a stray table read. Absent entries at each level must end the walk without a write. The directory frame number is changed in the middle of a walk. A design that reads the live register instead of a copy taken at the start would fetch from the wrong directory.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // Entries are 4 bytes wide.
  localparam int ENT_LG = 2;

  // Status and control bit positions inside an entry.
  localparam int PRESENT_BIT = 0;
  localparam int ACC_BIT     = 5;
  localparam int DIRTY_BIT   = 6;
  localparam int LARGE_BIT   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
  parameter int FRM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [FRM_W-1:0] frame_i,
  output logic [FRM_W-1:0] frame_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    frame_o <= '0;
    else if (we_i) frame_o <= frame_i;
  end
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] base_frame_i,
  input  logic [ADDR_W-1:0]       va_i,
  input  logic [ADDR_W-OFF_W-1:0] pde_frame_i,
  input  logic [ADDR_W-OFF_W-1:0] pte_frame_i,
  output logic [ADDR_W-1:0]       dir_addr_o,
  output logic [ADDR_W-1:0]       tbl_addr_o,
  output logic [ADDR_W-1:0]       small_pa_o,
  output logic [ADDR_W-1:0]       large_pa_o
);
  localparam int FRM_W  = ADDR_W - OFF_W;
  localparam int TIDX_W = OFF_W - ENT_LG;
  localparam int DIDX_W = FRM_W - TIDX_W;
  localparam int LOFF_W = OFF_W + TIDX_W;

  logic [DIDX_W-1:0] dir_idx;
  logic [TIDX_W-1:0] tbl_idx;

  always_comb begin
    dir_idx    = va_i[ADDR_W-1 -: DIDX_W];
    tbl_idx    = va_i[LOFF_W-1 -: TIDX_W];
    dir_addr_o = {base_frame_i, {OFF_W{1'b0}}} + (ADDR_W'(dir_idx) << ENT_LG);
    tbl_addr_o = {pde_frame_i, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENT_LG);
    small_pa_o = {pte_frame_i, va_i[OFF_W-1:0]};
    large_pa_o = {pde_frame_i[FRM_W-1 -: DIDX_W], va_i[LOFF_W-1:0]};
  end
endmodule

// File: rtl/pgwalk_status_upd.sv
module pgwalk_status_upd
  import pgwalk_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic             tbl_level_i,
  input  logic             pse_i,
  input  logic             write_i,
  output logic             present_o,
  output logic             large_o,
  output logic [ENT_W-1:0] new_o,
  output logic             changed_o
);
  logic             last_lvl;
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    present_o = entry_i[PRESENT_BIT];
    large_o   = !tbl_level_i && pse_i && entry_i[LARGE_BIT];
    last_lvl  = tbl_level_i || large_o;
    set_mask  = '0;
    set_mask[ACC_BIT]   = 1'b1;
    set_mask[DIRTY_BIT] = last_lvl && write_i;
    new_o     = entry_i | set_mask;
    changed_o = (new_o != entry_i);
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_we_i,
  input  logic [ADDR_W-OFF_W-1:0] base_frame_i,
  input  logic                    pse_en_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_vaddr_i,
  input  logic                    req_write_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_fault_o,
  output logic [ADDR_W-1:0]       rsp_paddr_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [ADDR_W-1:0]       mem_wdata_o,
  input  logic [ADDR_W-1:0]       mem_rdata_i
);
  localparam int FRM_W = ADDR_W - OFF_W;

  walk_st_e          st;
  logic [FRM_W-1:0]  base_live, base_lat;
  logic [ADDR_W-1:0] va_q, pde_q, pte_q, paddr_q;
  logic              wr_q, pse_q, fault_q;

  logic [ADDR_W-1:0] lvl_entry, upd_entry, dir_addr, tbl_addr, small_pa, large_pa;
  logic [FRM_W-1:0]  pde_frame, pte_frame;
  logic              tbl_lvl, ent_present, ent_large, ent_changed;

  pgwalk_base_reg #(.FRM_W(FRM_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (base_we_i),
    .frame_i (base_frame_i),
    .frame_o (base_live)
  );

  always_comb begin
    tbl_lvl   = (st == ST_TBL_RD) || (st == ST_TBL_WB);
    case (st)
      ST_DIR_RD, ST_TBL_RD: lvl_entry = mem_rdata_i;
      ST_DIR_WB:            lvl_entry = pde_q;
      default:              lvl_entry = pte_q;
    endcase
    pde_frame = (st == ST_DIR_RD) ? mem_rdata_i[ADDR_W-1:OFF_W] : pde_q[ADDR_W-1:OFF_W];
    pte_frame = (st == ST_TBL_RD) ? mem_rdata_i[ADDR_W-1:OFF_W] : pte_q[ADDR_W-1:OFF_W];
  end

  pgwalk_status_upd #(.ENT_W(ADDR_W)) u_upd (
    .entry_i     (lvl_entry),
    .tbl_level_i (tbl_lvl),
    .pse_i       (pse_q),
    .write_i     (wr_q),
    .present_o   (ent_present),
    .large_o     (ent_large),
    .new_o       (upd_entry),
    .changed_o   (ent_changed)
  );

  pgwalk_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_frame_i (base_lat),
    .va_i         (va_q),
    .pde_frame_i  (pde_frame),
    .pte_frame_i  (pte_frame),
    .dir_addr_o   (dir_addr),
    .tbl_addr_o   (tbl_addr),
    .small_pa_o   (small_pa),
    .large_pa_o   (large_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      base_lat <= '0;
      va_q     <= '0;
      pde_q    <= '0;
      pte_q    <= '0;
      paddr_q  <= '0;
      wr_q     <= 1'b0;
      pse_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid_i) begin
          va_q     <= req_vaddr_i;
          wr_q     <= req_write_i;
          pse_q    <= pse_en_i;
          base_lat <= base_live;
          fault_q  <= 1'b0;
          st       <= ST_DIR_RD;
        end
        ST_DIR_RD: if (mem_ready_i) begin
          pde_q <= mem_rdata_i;
          if (!ent_present) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            st      <= ST_RESP;
          end else if (ent_changed) begin
            st <= ST_DIR_WB;
          end else if (ent_large) begin
            paddr_q <= large_pa;
            st      <= ST_RESP;
          end else begin
            st <= ST_TBL_RD;
          end
        end
        ST_DIR_WB: if (mem_ready_i) begin
          if (ent_large) begin
            paddr_q <= large_pa;
            st      <= ST_RESP;
          end else begin
            st <= ST_TBL_RD;
          end
        end
        ST_TBL_RD: if (mem_ready_i) begin
          pte_q <= mem_rdata_i;
          if (!ent_present) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            st      <= ST_RESP;
          end else if (ent_changed) begin
            st <= ST_TBL_WB;
          end else begin
            paddr_q <= small_pa;
            st      <= ST_RESP;
          end
        end
        ST_TBL_WB: if (mem_ready_i) begin
          paddr_q <= small_pa;
          st      <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o = (st == ST_IDLE);
    rsp_valid_o = (st == ST_RESP);
    rsp_fault_o = fault_q;
    rsp_paddr_o = paddr_q;
    mem_valid_o = (st == ST_DIR_RD) || (st == ST_DIR_WB) ||
                  (st == ST_TBL_RD) || (st == ST_TBL_WB);
    mem_we_o    = (st == ST_DIR_WB) || (st == ST_TBL_WB);
    mem_addr_o  = tbl_lvl ? tbl_addr : dir_addr;
    mem_wdata_o = mem_we_o ? upd_entry : '0;
  end
endmodule

// File: rtl/pgwalk_checks.sv
module pgwalk_checks #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              rsp_valid_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] mem_wdata_o
);
  localparam int IDX_W = OFF_W - 2;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_valid_o && !rsp_valid_o)); // R1

  AST_DIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (mem_valid_o && !mem_we_o &&
      mem_addr_o[OFF_W-1:2] == $past(req_vaddr_i[ADDR_W-1 -: IDX_W]))); // R2

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> (mem_valid_o && $stable(mem_addr_o))); // R9

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_we_o) |-> (mem_wdata_o[5] && mem_wdata_o[0])); // R9

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o); // R11

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o))); // R12
endmodule

bind pgwalk_top pgwalk_checks #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [19:0] base_frame = '0;
  logic        pse_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] mem [int unsigned];
  int mem_wait = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] rd_log [4];

  always #5 clk = ~clk;

  pgwalk_top uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_we_i    (base_we),
    .base_frame_i (base_frame),
    .pse_en_i     (pse_en),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_vaddr_i  (req_vaddr),
    .req_write_i  (req_write),
    .rsp_valid_o  (rsp_valid),
    .rsp_fault_o  (rsp_fault),
    .rsp_paddr_o  (rsp_paddr),
    .mem_valid_o  (mem_valid),
    .mem_ready_i  (mem_ready),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata)
  );

  // Memory responder: drives at negedge, completes after mem_wait idle cycles.
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        cnt = 0;
      end else if (rst_n && mem_valid) begin
        if (cnt >= mem_wait) begin
          mem_ready = 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
          end
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [19:0] f);
    @(negedge clk);
    base_we = 1'b1;
    base_frame = f;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic start_req(input logic [31:0] va, input bit wr);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'h1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low after accept", 32'(req_ready), 32'h0);
  endtask

  task automatic wait_rsp(input bit exp_fault, input logic [31:0] exp_pa,
                          input int exp_rd, input int exp_wr, input string tag);
    int n;
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, {tag, " R11 response seen"}, 32'(rsp_valid), 32'h1);
    chk(rsp_fault == exp_fault, {tag, " R8 fault flag"}, 32'(rsp_fault), 32'(exp_fault));
    if (!exp_fault)
      chk(rsp_paddr == exp_pa, {tag, " R5 physical address"}, rsp_paddr, exp_pa);
    chk(rd_cnt == exp_rd, {tag, " R6 read count"}, 32'(rd_cnt), 32'(exp_rd));
    chk(wr_cnt == exp_wr, {tag, " R10 write count"}, 32'(wr_cnt), 32'(exp_wr));
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " R11 single-cycle strobe"}, 32'(rsp_valid), 32'h0);
  endtask

  task automatic run_walk(input logic [31:0] va, input bit wr, input bit exp_fault,
                          input logic [31:0] exp_pa, input int exp_rd, input int exp_wr,
                          input string tag);
    start_req(va, wr);
    wait_rsp(exp_fault, exp_pa, exp_rd, exp_wr, tag);
  endtask

  task automatic t_small_first;
    mem_wait = 0;
    pse_en = 1'b0;
    run_walk(32'h0040_1ABC, 1'b0, 1'b0, 32'h000B_8ABC, 2, 2, "small first");
    chk(rd_log[0] == 32'h0001_1004, "R2 directory address", rd_log[0], 32'h0001_1004);
    chk(rd_log[1] == 32'h0001_2004, "R4 table address", rd_log[1], 32'h0001_2004);
    chk(mem[32'h0001_1004] == 32'h0001_2021, "R9 dir accessed set", mem[32'h0001_1004], 32'h0001_2021);
    chk(mem[32'h0001_2004] == 32'h000B_8021, "R9 table accessed set, R10 no dirty on read",
        mem[32'h0001_2004], 32'h000B_8021);
  endtask

  task automatic t_small_repeat;
    mem_wait = 3;
    run_walk(32'h0040_1ABC, 1'b0, 1'b0, 32'h000B_8ABC, 2, 0, "R10 repeat no writeback");
  endtask

  task automatic t_small_write;
    mem_wait = 1;
    run_walk(32'h0040_1ABC, 1'b1, 1'b0, 32'h000B_8ABC, 2, 1, "R10 write sets dirty");
    chk(mem[32'h0001_2004] == 32'h000B_8061, "R10 table dirty", mem[32'h0001_2004], 32'h000B_8061);
    chk(mem[32'h0001_1004] == 32'h0001_2021, "R10 dir untouched", mem[32'h0001_1004], 32'h0001_2021);
  endtask

  task automatic t_large;
    mem_wait = 0;
    pse_en = 1'b1;
    run_walk(32'h00C3_4567, 1'b0, 1'b0, 32'h1E03_4567, 1, 0, "R6 large read");
    run_walk(32'h00C3_4567, 1'b1, 1'b0, 32'h1E03_4567, 1, 1, "R6 large write");
    chk(mem[32'h0001_100C] == 32'h1E00_00E1, "R10 large entry dirty", mem[32'h0001_100C], 32'h1E00_00E1);
  endtask

  task automatic t_large_off;
    mem_wait = 2;
    pse_en = 1'b0;
    run_walk(32'h00C3_4567, 1'b0, 1'b0, 32'h0005_5567, 2, 0, "R7 size bit ignored");
    chk(rd_log[1] == 32'h1E00_00D0, "R7 table read", rd_log[1], 32'h1E00_00D0);
  endtask

  task automatic t_faults;
    mem_wait = 0;
    run_walk(32'h0140_0000, 1'b1, 1'b1, 32'h0, 1, 0, "R8 dir absent");
    run_walk(32'h0180_7123, 1'b1, 1'b1, 32'h0, 2, 0, "R8 table absent");
    chk(mem[32'h0001_301C] == 32'h0009_9000, "R8 absent entry unchanged", mem[32'h0001_301C], 32'h0009_9000);
  endtask

  task automatic t_base_switch;
    mem_wait = 3;
    start_req(32'h0040_1ABC, 1'b0);
    base_we = 1'b1;
    base_frame = 20'h00021;
    @(negedge clk);
    base_we = 1'b0;
    wait_rsp(1'b0, 32'h000B_8ABC, 2, 0, "R3 walk keeps old base");
    chk(rd_log[0] == 32'h0001_1004, "R3 old directory used", rd_log[0], 32'h0001_1004);
    run_walk(32'h0040_1ABC, 1'b0, 1'b0, 32'h0007_7ABC, 2, 0, "R3 next walk new base");
    chk(rd_log[0] == 32'h0002_1004, "R3 new directory used", rd_log[0], 32'h0002_1004);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mem[32'h0001_1004] = 32'h0001_2001;
    mem[32'h0001_2004] = 32'h000B_8001;
    mem[32'h0001_100C] = 32'h1E00_00A1;
    mem[32'h1E00_00D0] = 32'h0005_5021;
    mem[32'h0001_1014] = 32'h0000_0000;
    mem[32'h0001_1018] = 32'h0001_3021;
    mem[32'h0001_301C] = 32'h0009_9000;
    mem[32'h0002_1004] = 32'h0002_2021;
    mem[32'h0002_2004] = 32'h0007_7061;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R11 reset no response", 32'(rsp_valid), 32'h0);
    chk(mem_valid == 1'b0, "R12 reset no access", 32'(mem_valid), 32'h0);
    set_base(20'h00011);
    t_small_first();
    t_small_repeat();
    t_small_write();
    t_large();
    t_large_off();
    t_faults();
    t_base_switch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule